// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Port

This block is one register-programmed I/O port of sixteen pins. Each pin can act as a plain software-controlled GPIO or be given to one of four peripheral functions. In GPIO mode the pin's driver takes its value from an output latch and its enable from a direction bit. Software updates both with write-one-to-set and write-one-to-clear addresses, so a single bit can change without a read-modify-write sequence. In function mode a 2-bit selector per pin picks which of four peripheral output/enable pairs drives the pad.

Pad inputs pass through a two-stage synchroniser. An input-enable bit per pin gates the synchronised value. The gated vector goes to the data read path and to an outgoing pin-interrupt vector, which a separate interrupt block consumes. A simple single-cycle register bus with a registered read port gives access to all state.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every register reads 0, so all pins are GPIO inputs with input enable off. pad_oe, pad_out and pint_out are all 0.
- R2: Word address 0 holds the function-enable bits (bit n for pin n) and reads back what was written. A pin whose bit is 0 drives pad_out from its output latch and pad_oe from its direction bit.
- R3: A write to address 3 sets the latch bits where the written data has a 1 and leaves the others unchanged. Reading address 3 or 4 returns the latch.
- R4: A write to address 4 clears the latch bits where the written data has a 1 and leaves the others unchanged. A write to address 2 loads the whole latch.
- R5: A write to address 5 sets direction bits (1 = output) and a write to address 6 clears them. Reading address 5 or 6 returns the direction bits.
- R6: Address 7 holds the input-enable bits. pint_out equals the synchronised pad input ANDed with input enable. A pad change reaches pint_out after two rising edges.
- R7: Reading address 2 returns, per pin, the latch if the pin is an output. Otherwise it returns the synchronised pad value ANDed with input enable.
- R8: A pin whose function-enable bit is 1 drives pad_out and pad_oe from the peripheral pair with index pin*4 + sel. Here sel is mux bits 2n+1:2n for pin n.
- R9: Address 1 holds the full 32-bit mux word and reads back what was written.
- R10: Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read. Addresses 8 to 15 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Raw pad input values |
| pad_out | output | 16 | Pad driver value |
| pad_oe | output | 16 | Pad driver enable |
| fn_out | input | 64 | Peripheral output values, index pin*4 + function |
| fn_oe | input | 64 | Peripheral output enables, index pin*4 + function |
| pint_out | output | 16 | Gated pin inputs to the interrupt block |

## Verification
A register write takes effect at the edge that samples it, so pad_out and pad_oe are due one edge after the write strobe. Peripheral inputs pass through combinationally. A read result is due one edge after bus_rd. A pad input change needs two edges before it shows on pint_out or in a data read. The bench drives inputs on falling edges and compares on falling edges. After each pad change it waits two full cycles, except in one directed case that samples after a single edge to confirm the old value still holds.

// File: rtl/gpio_mux_port_pkg.sv
// Shared constants and register address encoding for the multiplexed GPIO port.
package gpio_mux_port_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_FUNC = 4'd0,
        REG_MUX  = 4'd1,
        REG_DATA = 4'd2,
        REG_DSET = 4'd3,
        REG_DCLR = 4'd4,
        REG_DIRS = 4'd5,
        REG_DIRC = 4'd6,
        REG_INEN = 4'd7
    } port_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop captures the raw pad value.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_in;
            end
        end else begin : g_next
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_sel.sv
// Per-pin output steering: the GPIO latch/direction, or one of NFUNC
// peripheral output/enable pairs chosen by a select code.
// Assumes NFUNC is a power of two so every select code is valid.
module gpio_pin_sel #(
    parameter int NFUNC = 4,
    localparam int SEL_W = $clog2(NFUNC)
) (
    input  logic             fn_en,
    input  logic [SEL_W-1:0] sel,
    input  logic             gpio_out,
    input  logic             gpio_oe,
    input  logic [NFUNC-1:0] fn_out,
    input  logic [NFUNC-1:0] fn_oe,
    output logic             pad_out,
    output logic             pad_oe
);
    // Choose the driver source for this pin.
    always_comb begin
        if (fn_en) begin
            pad_out = fn_out[sel];
            pad_oe  = fn_oe[sel];
        end else begin
            pad_out = gpio_out;
            pad_oe  = gpio_oe;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
// Register file for the port: function enable, mux word, data latch with
// set/clear access, direction with set/clear access, input enable.
// Registered read port with one cycle of latency. Assumes NPINS*SEL_W
// equals BUS_W and NPINS is below BUS_W.
module gpio_port_regs
    import gpio_mux_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int SEL_W = 2,
    parameter int BUS_W = 32,
    localparam int MUX_W = NPINS * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_sync,
    output logic [NPINS-1:0]  fn_en_q,
    output logic [MUX_W-1:0]  mux_q,
    output logic [NPINS-1:0]  dat_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pint_out
);
    logic [NPINS-1:0] inen_q;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] in_gated;
    logic [NPINS-1:0] data_view;

    assign wbits     = bus_wdata[NPINS-1:0];
    assign in_gated  = pad_sync & inen_q;
    assign data_view = (dir_q & dat_q) | (~dir_q & in_gated);
    assign pint_out  = in_gated;

    // Register writes, including atomic set/clear updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_en_q <= '0;
            mux_q   <= '0;
            dat_q   <= '0;
            dir_q   <= '0;
            inen_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                REG_FUNC: fn_en_q <= wbits;
                REG_MUX:  mux_q   <= bus_wdata[MUX_W-1:0];
                REG_DATA: dat_q   <= wbits;
                REG_DSET: dat_q   <= dat_q | wbits;
                REG_DCLR: dat_q   <= dat_q & ~wbits;
                REG_DIRS: dir_q   <= dir_q | wbits;
                REG_DIRC: dir_q   <= dir_q & ~wbits;
                REG_INEN: inen_q  <= wbits;
                default:  ;
            endcase
        end
    end

    // Registered read mux; holds the last value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                REG_FUNC:           bus_rdata <= BUS_W'(fn_en_q);
                REG_MUX:            bus_rdata <= BUS_W'(mux_q);
                REG_DATA:           bus_rdata <= BUS_W'(data_view);
                REG_DSET, REG_DCLR: bus_rdata <= BUS_W'(dat_q);
                REG_DIRS, REG_DIRC: bus_rdata <= BUS_W'(dir_q);
                REG_INEN:           bus_rdata <= BUS_W'(inen_q);
                default:            bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
// Top of the multiplexed GPIO port: register file, pad input synchroniser
// and one output steering cell per pin. Peripheral pairs are flattened
// with index pin*NFUNC + function.
module gpio_mux_port
    import gpio_mux_port_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int NFUNC       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int BUS_W       = 32,
    localparam int SEL_W = $clog2(NFUNC),
    localparam int MUX_W = NPINS * SEL_W,
    localparam int FN_W  = NPINS * NFUNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [FN_W-1:0]   fn_out,
    input  logic [FN_W-1:0]   fn_oe,
    output logic [NPINS-1:0]  pint_out
);
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] fn_en_q;
    logic [MUX_W-1:0] mux_q;
    logic [NPINS-1:0] dat_q;
    logic [NPINS-1:0] dir_q;

    gpio_in_sync #(
        .WIDTH  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_port_regs #(
        .NPINS (NPINS),
        .SEL_W (SEL_W),
        .BUS_W (BUS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_sync  (pad_sync),
        .fn_en_q   (fn_en_q),
        .mux_q     (mux_q),
        .dat_q     (dat_q),
        .dir_q     (dir_q),
        .pint_out  (pint_out)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        gpio_pin_sel #(
            .NFUNC (NFUNC)
        ) u_sel (
            .fn_en    (fn_en_q[n]),
            .sel      (mux_q[n*SEL_W +: SEL_W]),
            .gpio_out (dat_q[n]),
            .gpio_oe  (dir_q[n]),
            .fn_out   (fn_out[n*NFUNC +: NFUNC]),
            .fn_oe    (fn_oe[n*NFUNC +: NFUNC]),
            .pad_out  (pad_out[n]),
            .pad_oe   (pad_oe[n])
        );
    end
endmodule

// File: rtl/gpio_mux_port_chk.sv
// Protocol checker for gpio_mux_port, attached by bind. Observes ports
// plus the function-enable register to know which pins are GPIO-owned.
module gpio_mux_port_chk
    import gpio_mux_port_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int BUS_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pint_out,
    input logic [NPINS-1:0]  fn_en
);
    // R1: one cycle after reset, nothing is driven and no interrupt input is forwarded
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && pint_out == '0));

    // R3: set-bits write raises the GPIO-owned pads it names
    p_dset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DSET) |=>
        ((pad_out & ~fn_en & $past(bus_wdata[NPINS-1:0])) == (~fn_en & $past(bus_wdata[NPINS-1:0]))));

    // R4: clear-bits write lowers the GPIO-owned pads it names
    p_dclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DCLR) |=>
        ((pad_out & ~fn_en & $past(bus_wdata[NPINS-1:0])) == '0));

    // R5: direction-set write enables the GPIO-owned drivers it names
    p_dirs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIRS) |=>
        ((pad_oe & ~fn_en & $past(bus_wdata[NPINS-1:0])) == (~fn_en & $past(bus_wdata[NPINS-1:0]))));

    // R6: after input enable is written, only enabled pins can reach the interrupt vector
    p_inen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_INEN) |=>
        ((pint_out & ~$past(bus_wdata[NPINS-1:0])) == '0));

    // R10: unmapped addresses read as zero one cycle later
    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > REG_INEN) |=> (bus_rdata == '0));

    // R10: read data holds while no read is issued
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && rst_n) |=> $stable(bus_rdata));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .NPINS (NPINS),
    .BUS_W (BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pint_out  (pint_out),
    .fn_en     (fn_en_q)
);

// File: tb/sim_gpio_mux_port.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a reference model held in bench variables.
module sim_gpio_mux_port;
    localparam int NP = 16;
    localparam int NF = 4;
    localparam int BW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP*NF-1:0] fn_out = '0;
    logic [NP*NF-1:0] fn_oe = '0;
    logic [NP-1:0] pint_out;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [NP-1:0] m_fn = '0, m_dat = '0, m_dir = '0, m_inen = '0, m_pad = '0;
    logic [BW-1:0] m_mux = '0;

    always #4 clk = ~clk;

    gpio_mux_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .fn_out    (fn_out),
        .fn_oe     (fn_oe),
        .pint_out  (pint_out)
    );

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] r;
        for (int n = 0; n < NP; n++) begin
            int s = int'(m_mux[2*n +: 2]);
            r[n] = m_fn[n] ? fn_out[n*NF + s] : m_dat[n];
        end
        return r;
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] r;
        for (int n = 0; n < NP; n++) begin
            int s = int'(m_mux[2*n +: 2]);
            r[n] = m_fn[n] ? fn_oe[n*NF + s] : m_dir[n];
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] exp_rd(input int a);
        case (a)
            0: return BW'(m_fn);
            1: return m_mux;
            2: return BW'((m_dir & m_dat) | (~m_dir & m_pad & m_inen));
            3, 4: return BW'(m_dat);
            5, 6: return BW'(m_dir);
            7: return BW'(m_inen);
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            0: m_fn = d[NP-1:0];
            1: m_mux = d;
            2: m_dat = d[NP-1:0];
            3: m_dat = m_dat | d[NP-1:0];
            4: m_dat = m_dat & ~d[NP-1:0];
            5: m_dir = m_dir | d[NP-1:0];
            6: m_dir = m_dir & ~d[NP-1:0];
            7: m_inen = d[NP-1:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input string req, input int a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    task automatic set_pad(input logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v; m_pad = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic pins_chk(input string req);
        chk({req, " pad_out"}, BW'(pad_out), BW'(exp_out()));
        chk({req, " pad_oe"}, BW'(pad_oe), BW'(exp_oe()));
        chk({req, " pint_out"}, BW'(pint_out), BW'(m_pad & m_inen));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : main
        logic [BW-1:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at pins and through every readable address
        pins_chk("R1");
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", a);

        // R3: set-bits writes, zero bits leave latch alone
        wr(3, 32'h0000_00A5);
        rd_chk("R3 latch read", 3);
        wr(3, 32'h0000_0100);
        rd_chk("R3 zeros unchanged", 3);
        chk("R2 gpio pad_out from latch", BW'(pad_out), 32'h0000_01A5);

        // R4: clear-bits writes and whole-latch load
        wr(4, 32'h0000_0021);
        rd_chk("R4 clear", 4);
        wr(2, 32'h0000_F00F);
        rd_chk("R4 full load", 4);

        // R5: direction set/clear with readback from both addresses
        wr(5, 32'h0000_00F0);
        rd_chk("R5 dir set", 5);
        wr(6, 32'h0000_0030);
        rd_chk("R5 dir clear", 6);
        pins_chk("R5");

        // R6/R7: input gating and output latch read
        set_pad(16'hFFFF);
        pins_chk("R6 inen off");
        rd_chk("R7 data read inen off", 2);
        wr(7, 32'h0000_0F0F);
        pins_chk("R6 inen on");
        rd_chk("R7 data read mixed", 2);

        // R6: two-edge synchroniser latency
        @(negedge clk);
        pad_in = 16'h0000;
        @(negedge clk);
        chk("R6 old value after one edge", BW'(pint_out), 32'h0000_0F0F);
        @(negedge clk);
        m_pad = 16'h0000;
        chk("R6 new value after two edges", BW'(pint_out), 32'h0);

        // R8/R9: function mode selects each of the four peripheral pairs
        wr(1, 32'h1B1B_E4E4);
        rd_chk("R9 mux readback", 1);
        wr(0, 32'h0000_0F0F);
        rd_chk("R2 func readback", 0);
        @(negedge clk);
        fn_out = 64'h8421_8421_F0F0_1248;
        fn_oe  = 64'h1248_8421_0F0F_4812;
        #1;
        pins_chk("R8 function select");

        // R10: unmapped address writes ignored and read as zero
        wr(9, 32'hFFFF_FFFF);
        wr(15, 32'hFFFF_FFFF);
        for (int a = 0; a < 8; a++) rd_chk("R10 state kept", a);
        rd_chk("R10 unmapped read", 9);
        pins_chk("R10");

        // R2: leaving function mode returns pins to latch/direction
        wr(0, 32'h0);
        pins_chk("R2 back to gpio");

        // Random traffic across all requirements
        for (int i = 0; i < 400; i++) begin
            int op = int'($urandom_range(0, 9));
            if (op < 7) begin
                wr(int'($urandom_range(0, 10)), $urandom());
            end else if (op == 7) begin
                set_pad(16'($urandom()));
            end else begin
                @(negedge clk);
                fn_out = {$urandom(), $urandom()};
                fn_oe  = {$urandom(), $urandom()};
            end
            @(negedge clk);
            pins_chk("R8 random pins");
            rd_chk("R7 random read", int'($urandom_range(0, 11)));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule